// File: doc/BRIEF.md
# Synthesizer Double-Buffered Programming Interface

This block stores the divider programming for an integer-N frequency synthesizer. A 20-bit staging word holds the prescaler enable, the 9-bit main divide value, the 6-bit reference divide value and the 4-bit swallow count. A second copy of the same width holds the active settings. Software or a controller fills the staging word, then a transfer edge copies it into the active copy. Because the staging word can be filled while the active copy keeps driving the counters, a new channel can be prepared ahead of time and made active at a single moment.

The staging word can be loaded in two ways. The first is a three-wire serial stream of 20 bits, sent MSB first. The second is a set of byte strobes that place bits from an 8-bit bus into split fields. A third, direct mode bypasses both registers and passes the main and swallow values straight from dedicated pins. A separate 8-bit feature byte is loaded by serial shift or by a bus strobe. In each register mode, a select pin chooses whether the staging or the active copy drives the outputs.

All pins except the mode and select pins are brought into one system clock through two-flop synchronizers. Rising edges are detected after the synchronizers. A strobe or serial clock edge shows at the outputs three clocks after it is sampled.

Top module: `synth_prog_if`

## Requirements
- R1: After reset, with the block in parallel mode, m_o, a_o, r_o, pre_en_o and feat_o are all zero whatever the select pin.
- R2: The mode pins decode as follows: dir_mode_i=1 gives direct mode. dir_mode_i=0 with ser_mode_i=1 gives serial mode. dir_mode_i=0 with ser_mode_i=0 gives parallel mode.
- R3: In serial mode, with ld_n_i low and feat_en_i low, each rising sclk_i edge shifts in one sdata_i bit. The 20-bit frame is sent MSB first in the order {pre_en, M[8:0], R[5:0], A[3:0]}, so pre_en is the first bit.
- R4: The staging word changes only when the 20th bit of a frame arrives. Taking ld_n_i high discards a partial frame, and the next frame starts counting from its first bit.
- R5: In serial mode, while feat_en_i is high, sclk_i edges shift sdata_i MSB first into the 8-bit feature byte, and the staging word is not touched.
- R6: A rising edge on ld_n_i or on hop_i copies the staging word into the active copy. At no other time does the active copy change.
- R7: When the mode's select pin is 1, the outputs show the staging word; when it is 0, they show the active copy. Serial mode uses sel_ser_i and parallel mode uses sel_par_i.
- R8: In parallel mode, a rising edge of wr_lo_i loads bus_i[7] into pre_en and bus_i[6:0] into M[6:0].
- R9: In parallel mode, a rising edge of wr_hi_i loads bus_i[3:2] into R[5:4] and bus_i[1:0] into M[8:7].
- R10: In parallel mode, a rising edge of wr_a_i loads bus_i[7:4] into R[3:0] and bus_i[3:0] into A[3:0]. A rising edge of feat_en_i loads bus_i into the feature byte.
- R11: In direct mode, m_o equals dir_m_i and a_o equals dir_a_i, r_o is zero and pre_en_o is 0 (prescaler in use). Byte strobes and serial edges leave both stored copies unchanged.
- R12: The byte strobes have no effect in serial mode, and sclk_i has no effect in parallel mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dir_mode_i | input | 1 | Direct mode select |
| ser_mode_i | input | 1 | Serial (1) or parallel (0) when not direct |
| sclk_i | input | 1 | Serial shift clock |
| sdata_i | input | 1 | Serial data |
| ld_n_i | input | 1 | Serial load enable, low while shifting; rising edge transfers |
| feat_en_i | input | 1 | Serial feature shift enable / parallel feature strobe |
| sel_ser_i | input | 1 | Output copy select in serial mode |
| sel_par_i | input | 1 | Output copy select in parallel mode |
| bus_i | input | 8 | Parallel data bus |
| wr_lo_i | input | 1 | Strobe for pre_en and M[6:0] |
| wr_hi_i | input | 1 | Strobe for R[5:4] and M[8:7] |
| wr_a_i | input | 1 | Strobe for R[3:0] and A[3:0] |
| hop_i | input | 1 | Transfer strobe |
| dir_m_i | input | 9 | Main divide value in direct mode |
| dir_a_i | input | 4 | Swallow count in direct mode |
| m_o | output | 9 | Main divide value |
| a_o | output | 4 | Swallow count |
| r_o | output | 6 | Reference divide value |
| pre_en_o | output | 1 | Prescaler enable, active low |
| feat_o | output | 8 | Feature byte |

## Verification
The case that is hardest to reach is a serial frame that is cut short and then followed by a full frame. The staging word must ignore the fragment, and the bit counter must restart at the first bit of the next frame. The bench shifts a random number of bits between 1 and 19, raises ld_n_i, and then sends a complete random frame. It checks the staging copy after each step, using the bench's own field packing. Random byte strobes in the wrong mode and in direct mode come next, and they must leave both copies unchanged when the bench switches back to a register mode.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
  localparam int unsigned M_W    = 9;
  localparam int unsigned R_W    = 6;
  localparam int unsigned A_W    = 4;
  localparam int unsigned FEAT_W = 8;
  localparam int unsigned BUS_W  = 8;
  localparam int unsigned FRAME_W = 1 + M_W + R_W + A_W;

  typedef struct packed {
    logic           pre_en;
    logic [M_W-1:0] m;
    logic [R_W-1:0] r;
    logic [A_W-1:0] a;
  } prog_word_t;

  typedef enum logic [1:0] {
    MODE_PAR = 2'd0,
    MODE_SER = 2'd1,
    MODE_DIR = 2'd2
  } if_mode_e;

  // strobe vector slots
  localparam int unsigned S_SCLK  = 0;
  localparam int unsigned S_SDAT  = 1;
  localparam int unsigned S_LDN   = 2;
  localparam int unsigned S_FEAT  = 3;
  localparam int unsigned S_WRLO  = 4;
  localparam int unsigned S_WRHI  = 5;
  localparam int unsigned S_WRA   = 6;
  localparam int unsigned S_HOP   = 7;
  localparam int unsigned S_NUM   = 8;
endpackage

// File: rtl/sp_strobe_sync.sv
module sp_strobe_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [W-1:0]             prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= raw_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[g] <= '0;
      else         stg_q[g] <= stg_q[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= stg_q[STAGES-1];
  end

  assign lvl_o  = stg_q[STAGES-1];
  assign rise_o = stg_q[STAGES-1] & ~prev_q;

  AST_RISE_NEEDS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rise_o) |=> ((rise_o & $past(rise_o)) == '0)); // R6
endmodule

// File: rtl/sp_serial_shift.sv
module sp_serial_shift
  import synth_prog_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               shift_i,
  input  logic               bit_i,
  input  logic               clr_i,
  output logic               frame_vld_o,
  output logic [FRAME_W-1:0] frame_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (shift_i) begin
      sh_q  <= {sh_q[FRAME_W-2:0], bit_i};
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign frame_vld_o = shift_i && !clr_i && (cnt_q == LAST);
  assign frame_o     = {sh_q[FRAME_W-2:0], bit_i};

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R4
  AST_FRAME_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_vld_o |=> cnt_q == '0); // R4
  AST_CLR_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0); // R4
endmodule

// File: rtl/sp_reg_bank.sv
module sp_reg_bank
  import synth_prog_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_vld_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               feat_sh_i,
  input  logic               feat_bit_i,
  input  logic               wr_lo_i,
  input  logic               wr_hi_i,
  input  logic               wr_a_i,
  input  logic               wr_feat_i,
  input  logic [BUS_W-1:0]   bus_i,
  input  logic               xfer_i,
  output prog_word_t         prim_o,
  output prog_word_t         sec_o,
  output logic [FEAT_W-1:0]  feat_o
);
  prog_word_t        prim_q, sec_q;
  logic [FEAT_W-1:0] feat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prim_q <= '0;
    end else begin
      if (frame_vld_i) prim_q <= prog_word_t'(frame_i);
      if (wr_lo_i) begin
        prim_q.pre_en <= bus_i[7];
        prim_q.m[6:0] <= bus_i[6:0];
      end
      if (wr_hi_i) begin
        prim_q.r[5:4] <= bus_i[3:2];
        prim_q.m[8:7] <= bus_i[1:0];
      end
      if (wr_a_i) begin
        prim_q.r[3:0] <= bus_i[7:4];
        prim_q.a      <= bus_i[3:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sec_q <= '0;
    else if (xfer_i) sec_q <= prim_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        feat_q <= '0;
    else if (wr_feat_i) feat_q <= bus_i;
    else if (feat_sh_i) feat_q <= {feat_q[FEAT_W-2:0], feat_bit_i};
  end

  assign prim_o = prim_q;
  assign sec_o  = sec_q;
  assign feat_o = feat_q;

  AST_XFER_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_i |=> sec_q == $past(prim_q)); // R6
  AST_SEC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_i |=> $stable(sec_q)); // R6
  AST_LO_FIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_lo_i && !frame_vld_i) |=> {prim_q.pre_en, prim_q.m[6:0]} == $past(bus_i)); // R8
  AST_A_FIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_a_i && !frame_vld_i) |=> {prim_q.r[3:0], prim_q.a} == $past(bus_i)); // R10
endmodule

// File: rtl/synth_prog_if.sv
module synth_prog_if
  import synth_prog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dir_mode_i,
  input  logic              ser_mode_i,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              ld_n_i,
  input  logic              feat_en_i,
  input  logic              sel_ser_i,
  input  logic              sel_par_i,
  input  logic [BUS_W-1:0]  bus_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic              wr_a_i,
  input  logic              hop_i,
  input  logic [M_W-1:0]    dir_m_i,
  input  logic [A_W-1:0]    dir_a_i,
  output logic [M_W-1:0]    m_o,
  output logic [A_W-1:0]    a_o,
  output logic [R_W-1:0]    r_o,
  output logic              pre_en_o,
  output logic [FEAT_W-1:0] feat_o
);
  if_mode_e           mode;
  logic [S_NUM-1:0]   raw, lvl, rise;
  logic               is_ser, is_par;
  logic               ser_shift, feat_shift, frame_vld;
  logic [FRAME_W-1:0] frame;
  prog_word_t         prim, sec, shown;

  always_comb begin
    if (dir_mode_i)      mode = MODE_DIR;
    else if (ser_mode_i) mode = MODE_SER;
    else                 mode = MODE_PAR;
  end
  assign is_ser = (mode == MODE_SER);
  assign is_par = (mode == MODE_PAR);

  always_comb begin
    raw         = '0;
    raw[S_SCLK] = sclk_i;
    raw[S_SDAT] = sdata_i;
    raw[S_LDN]  = ld_n_i;
    raw[S_FEAT] = feat_en_i;
    raw[S_WRLO] = wr_lo_i;
    raw[S_WRHI] = wr_hi_i;
    raw[S_WRA]  = wr_a_i;
    raw[S_HOP]  = hop_i;
  end

  sp_strobe_sync #(.W(S_NUM), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .raw_i (raw),
    .lvl_o (lvl),
    .rise_o(rise)
  );

  assign ser_shift  = is_ser && rise[S_SCLK] && !lvl[S_LDN] && !lvl[S_FEAT];
  assign feat_shift = is_ser && rise[S_SCLK] && lvl[S_FEAT];

  sp_serial_shift u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_i    (ser_shift),
    .bit_i      (lvl[S_SDAT]),
    .clr_i      (lvl[S_LDN]),
    .frame_vld_o(frame_vld),
    .frame_o    (frame)
  );

  sp_reg_bank u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frame_vld_i(frame_vld),
    .frame_i    (frame),
    .feat_sh_i  (feat_shift),
    .feat_bit_i (lvl[S_SDAT]),
    .wr_lo_i    (is_par && rise[S_WRLO]),
    .wr_hi_i    (is_par && rise[S_WRHI]),
    .wr_a_i     (is_par && rise[S_WRA]),
    .wr_feat_i  (is_par && rise[S_FEAT]),
    .bus_i      (bus_i),
    .xfer_i     (rise[S_LDN] || rise[S_HOP]),
    .prim_o     (prim),
    .sec_o      (sec),
    .feat_o     (feat_o)
  );

  always_comb begin
    unique case (mode)
      MODE_SER: shown = sel_ser_i ? prim : sec;
      MODE_PAR: shown = sel_par_i ? prim : sec;
      default: begin
        shown        = '0;
        shown.m      = dir_m_i;
        shown.a      = dir_a_i;
      end
    endcase
  end

  assign m_o      = shown.m;
  assign a_o      = shown.a;
  assign r_o      = shown.r;
  assign pre_en_o = shown.pre_en;

  AST_DIR_PRIM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_mode_i && $past(dir_mode_i)) |-> $stable(prim)); // R11
  AST_SER_NO_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_ser && !frame_vld) |=> $stable(prim)); // R12
endmodule

// File: tb/synth_prog_if_bench.sv
`timescale 1ns/1ps
module synth_prog_if_bench;
  logic clk = 0, rst_n = 0;
  logic dir_mode = 0, ser_mode = 0, sclk = 0, sdata = 0, ld_n = 1, feat_en = 0;
  logic sel_ser = 0, sel_par = 0, wr_lo = 0, wr_hi = 0, wr_a = 0, hop = 0;
  logic [7:0] bus = 0;
  logic [8:0] dir_m = 0;
  logic [3:0] dir_a = 0;
  logic [8:0] m_o;
  logic [3:0] a_o;
  logic [5:0] r_o;
  logic pre_en_o;
  logic [7:0] feat_o;

  logic [19:0] e_prim = 0, e_sec = 0;
  logic [7:0]  e_feat = 0;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  synth_prog_if u_synth_prog_if (
    .clk_i(clk), .rst_ni(rst_n), .dir_mode_i(dir_mode), .ser_mode_i(ser_mode),
    .sclk_i(sclk), .sdata_i(sdata), .ld_n_i(ld_n), .feat_en_i(feat_en),
    .sel_ser_i(sel_ser), .sel_par_i(sel_par), .bus_i(bus), .wr_lo_i(wr_lo),
    .wr_hi_i(wr_hi), .wr_a_i(wr_a), .hop_i(hop), .dir_m_i(dir_m), .dir_a_i(dir_a),
    .m_o(m_o), .a_o(a_o), .r_o(r_o), .pre_en_o(pre_en_o), .feat_o(feat_o));

  // word layout {pre_en, M[8:0], R[5:0], A[3:0]}
  function automatic logic [27:0] expect_out();
    logic [19:0] w;
    if (dir_mode) return {1'b0, dir_m, 6'd0, dir_a, e_feat};
    w = (ser_mode ? sel_ser : sel_par) ? e_prim : e_sec;
    return {w, e_feat};
  endfunction

  task automatic check(string req);
    logic [27:0] got, exp;
    @(negedge clk);
    got = {pre_en_o, m_o, r_o, a_o, feat_o};
    exp = expect_out();
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse(ref logic s);
    s = 1; wait_clk(4);
    s = 0; wait_clk(4);
  endtask

  task automatic sbit(logic b);
    sdata = b; wait_clk(1);
    sclk = 1; wait_clk(4);
    sclk = 0; wait_clk(4);
  endtask

  task automatic ser_bits(logic [19:0] w, int n);
    ld_n = 0; wait_clk(4);
    for (int i = 19; i > 19 - n; i--) sbit(w[i]);
  endtask

  task automatic ld_rise();
    ld_n = 1; wait_clk(4);
    e_sec = e_prim;
  endtask

  task automatic par_write(int which, logic [7:0] d);
    bus = d; wait_clk(1);
    case (which)
      0: begin pulse(wr_lo);   if (!ser_mode && !dir_mode) begin e_prim[19] = d[7]; e_prim[16:10] = d[6:0]; end end
      1: begin pulse(wr_hi);   if (!ser_mode && !dir_mode) begin e_prim[9:8] = d[3:2]; e_prim[18:17] = d[1:0]; end end
      2: begin pulse(wr_a);    if (!ser_mode && !dir_mode) begin e_prim[7:4] = d[7:4]; e_prim[3:0] = d[3:0]; end end
      3: begin pulse(feat_en); if (!ser_mode && !dir_mode) e_feat = d; end
      default: begin pulse(hop); e_sec = e_prim; end
    endcase
  endtask

  initial begin
    logic [19:0] w;
    int k;
    void'($urandom(32'h5eed_0a17));
    wait_clk(3);
    rst_n = 1;
    wait_clk(6);
    sel_par = 0; check("R1");
    sel_par = 1; check("R1");

    // parallel directed field mapping
    par_write(0, 8'hA5); check("R8");
    par_write(1, 8'h0E); check("R9");
    par_write(2, 8'h3C); check("R10");
    par_write(3, 8'h96); check("R10");
    sel_par = 0; check("R6");
    par_write(4, 8'h00); check("R6");

    // parallel random
    for (int i = 0; i < 40; i++) begin
      sel_par = $urandom_range(0, 1);
      par_write($urandom_range(0, 4), 8'($urandom));
      check("R7");
    end

    // serial mode: directed frame then random
    ser_mode = 1; sel_ser = 1; check("R2");
    w = 20'h8_0001;
    ser_bits(w, 20); e_prim = w; check("R3");
    sel_ser = 0; check("R7");
    ld_rise(); check("R6");
    for (int i = 0; i < 12; i++) begin
      w = 20'($urandom);
      sel_ser = $urandom_range(0, 1);
      ser_bits(w, 20); e_prim = w; check("R3");
      ld_rise(); check("R6");
    end

    // partial frame abort
    sel_ser = 1;
    for (int i = 0; i < 4; i++) begin
      k = $urandom_range(1, 19);
      ser_bits(20'($urandom), k); check("R4");
      ld_n = 1; wait_clk(4); e_sec = e_prim; check("R4");
      w = 20'($urandom);
      ser_bits(w, 20); e_prim = w; check("R4");
      ld_rise();
    end

    // feature byte shift
    for (int i = 0; i < 4; i++) begin
      logic [7:0] f;
      f = 8'($urandom);
      feat_en = 1; wait_clk(4);
      for (int b = 7; b >= 0; b--) sbit(f[b]);
      feat_en = 0; wait_clk(4);
      e_feat = f; check("R5");
    end

    // byte strobes ignored in serial mode
    par_write(0, 8'hFF); check("R12");
    par_write(2, 8'hFF); check("R12");

    // sclk ignored in parallel mode
    ser_mode = 0; sel_par = 1; check("R2");
    ld_n = 0; wait_clk(4);
    for (int b = 0; b < 20; b++) sbit(1'b1);
    ld_n = 1; wait_clk(4); e_sec = e_prim; check("R12");

    // direct mode
    dir_mode = 1;
    for (int i = 0; i < 8; i++) begin
      dir_m = 9'($urandom); dir_a = 4'($urandom);
      ser_mode = $urandom_range(0, 1);
      check("R11");
    end
    ser_mode = 0;
    par_write(0, 8'h7E); par_write(1, 8'h0F); par_write(2, 8'hC3);
    check("R11");
    dir_mode = 0; sel_par = 1; check("R11");
    sel_par = 0; check("R11");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule